// File: doc/BRIEF.md
# Isochronous Endpoint Double-Buffer Controller

This block holds the two packet buffers of one isochronous endpoint in a full-speed USB device and decides which buffer faces the bus and which faces software. A frame timer runs freely with a period of one millisecond, expressed as a parameter in clock cycles. Each received start-of-frame strobe brings it back into phase. Each frame boundary produces a one-cycle frame pulse and sets a sticky frame interrupt. The two buffers trade places on that boundary and at no other time.

The parameter `IS_IN` selects the direction. For a device-to-host endpoint, software writes 32-bit words and a byte count into its buffer and then marks the buffer ready. The packet engine reads bytes from the other buffer. It gets a zero-length count if that buffer was never marked ready. For a host-to-device endpoint, the engine stores every received byte into its buffer whatever that buffer holds. After the swap, software reads whole words and the byte count. In both directions the first byte on the bus sits in the least significant byte of a word. Each buffer keeps its own byte count and ready flag, and both travel with it through a swap.

Top module: `iso_dbuf_ep`

## Requirements
- R1: With no start-of-frame strobe, `frame_o` is high for one cycle every `FRAME_CYCLES` cycles.
- R2: A start-of-frame strobe sampled on a clock edge makes `frame_o` high right after that edge. The next pulse follows `FRAME_CYCLES` cycles later.
- R3: `irq_o` goes high one cycle after every frame pulse and stays high until `irq_ack_i` is sampled. A frame pulse and an acknowledge on the same edge leave `irq_o` high.
- R4: The buffers swap on the edge after a frame pulse and at no other time. Issuing ready (`cpu_validate_i`) or `cpu_clear_i` never causes a swap.
- R5: In IN mode, `tx_len_o` gives the byte count of the bus-side buffer if that buffer is marked ready, and 0 if it is not, which means a zero-length packet.
- R6: In IN mode, byte k of the transmitted stream is bits [8*(k mod 4)+7 : 8*(k mod 4)] of the (k div 4)-th word software wrote since the last ready, clear or swap. `tx_next_i` advances to the next byte.
- R7: In OUT mode, the word at `cpu_rdata_o` holds received bytes 4n to 4n+3, with the first byte in bits 7:0. `cpu_rd_i` advances to word n+1.
- R8: In OUT mode, every received byte is stored whatever the state of the bus-side buffer. The bus-side count restarts at 0 on each swap and stops at `MAX_BYTES`, and bytes past that limit are dropped. After the swap, `cpu_len_o` shows the count.
- R9: In IN mode, `tx_done_i` clears the ready flag of the bus-side buffer, so `tx_len_o` becomes 0. When that buffer returns to software, `cpu_valid_o` is 0.
- R10: Each buffer keeps its own byte count through swaps. After every swap, `cpu_len_o` shows the count stored with the buffer now on the software side.
- R11: `cpu_clear_i` sets the software-side count and ready flag to 0. A length write above `MAX_BYTES` is clamped to `MAX_BYTES`.
- R12: During reset, `frame_o`, `irq_o`, `cpu_len_o`, `tx_len_o` and `cpu_valid_o` are all 0.

Every rule that applies to the top module is listed here. The checks follow from these rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame token received (one-cycle strobe) |
| frame_o | output | 1 | One-cycle frame boundary pulse |
| irq_o | output | 1 | Sticky frame interrupt |
| irq_ack_i | input | 1 | Clears the frame interrupt |
| cpu_wr_i | input | 1 | Write one word into the software-side buffer (IN) |
| cpu_wdata_i | input | 32 | Word to write |
| cpu_rd_i | input | 1 | Advance to the next word of the software-side buffer (OUT) |
| cpu_rdata_o | output | 32 | Current word of the software-side buffer |
| cpu_len_wr_i | input | 1 | Load the software-side byte count (IN) |
| cpu_len_i | input | clog2(MAX_BYTES+1) | Byte count to load |
| cpu_len_o | output | clog2(MAX_BYTES+1) | Byte count of the software-side buffer |
| cpu_validate_i | input | 1 | Mark the software-side buffer ready (IN) |
| cpu_clear_i | input | 1 | Empty the software-side buffer |
| cpu_valid_o | output | 1 | Ready flag of the software-side buffer |
| tx_len_o | output | clog2(MAX_BYTES+1) | Bytes to send for the next IN token; 0 means a zero-length packet |
| tx_byte_o | output | 8 | Current byte of the bus-side buffer |
| tx_next_i | input | 1 | Engine consumed the current byte |
| tx_done_i | input | 1 | Engine finished sending the packet |
| rx_byte_i | input | 8 | Received byte (OUT) |
| rx_wr_i | input | 1 | Store `rx_byte_i` into the bus-side buffer |

## Verification
The frame timer is run both ways. It is left free-running to check the bare period, and it is hit with a mid-frame start-of-frame to check that the phase restarts. An acknowledge lands on the same edge as a pulse to separate "set wins" from "clear wins". On the IN side, a validated 13-byte packet with four distinct words exposes byte-lane or word-order errors. An unvalidated buffer separates a zero-length reply from a stale one. Ready and clear commands are issued between swaps, and the software-side count is read after each. A wrongly toggled buffer would show the other buffer's count. On the OUT side, a short packet, an overlong one and a rewrite of a buffer still holding data separate the saturation and always-write rules from ordinary storage.

// File: rtl/iso_dbuf_pkg.sv
package iso_dbuf_pkg;
  localparam int unsigned LANES = 4;
  typedef logic [7:0]         byte_t;
  typedef logic [8*LANES-1:0] word_t;
endpackage

// File: rtl/iso_rst_sync.sv
module iso_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/iso_frame_timer.sv
module iso_frame_timer #(
  parameter int unsigned FRAME_CYCLES = 12000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  output logic frame_o
);
  localparam int unsigned CW = $clog2(FRAME_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(FRAME_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          pulse_q, tick;

  // a SoF both marks the boundary and restarts the phase
  always_comb begin
    tick  = sof_i || (cnt_q == LAST);
    cnt_n = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      pulse_q <= tick;
    end
  end

  assign frame_o = pulse_q;
endmodule

// File: rtl/iso_bank.sv
module iso_bank
  import iso_dbuf_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 64
) (
  input  logic                             clk_i,
  input  logic                             word_we_i,
  input  logic [$clog2(MAX_BYTES/4)-1:0]   word_idx_i,
  input  word_t                            word_i,
  output word_t                            word_o,
  input  logic                             byte_we_i,
  input  logic [$clog2(MAX_BYTES)-1:0]     byte_idx_i,
  input  byte_t                            byte_i,
  output byte_t                            byte_o
);
  byte_t mem [MAX_BYTES];

  always_ff @(posedge clk_i) begin
    if (word_we_i) begin
      for (int j = 0; j < 4; j++) mem[{word_idx_i, j[1:0]}] <= word_i[8*j +: 8];
    end
    if (byte_we_i) mem[byte_idx_i] <= byte_i;
  end

  // little endian: lowest address in the low lane
  assign word_o = {mem[{word_idx_i, 2'd3}], mem[{word_idx_i, 2'd2}],
                   mem[{word_idx_i, 2'd1}], mem[{word_idx_i, 2'd0}]};
  assign byte_o = mem[byte_idx_i];
endmodule

// File: rtl/iso_dbuf_ctrl.sv
module iso_dbuf_ctrl #(
  parameter bit          IS_IN     = 1'b1,
  parameter int unsigned MAX_BYTES = 64,
  localparam int unsigned LW    = $clog2(MAX_BYTES + 1),
  localparam int unsigned BW    = $clog2(MAX_BYTES),
  localparam int unsigned WORDS = MAX_BYTES / 4,
  localparam int unsigned WW    = $clog2(WORDS),
  localparam int unsigned PW    = $clog2(WORDS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          swap_i,
  input  logic          irq_ack_i,
  input  logic          cpu_wr_i,
  input  logic          cpu_rd_i,
  input  logic          cpu_len_wr_i,
  input  logic [LW-1:0] cpu_len_i,
  input  logic          cpu_validate_i,
  input  logic          cpu_clear_i,
  input  logic          tx_next_i,
  input  logic          tx_done_i,
  input  logic          rx_wr_i,
  output logic          bus_sel_o,
  output logic [WW-1:0] cpu_widx_o,
  output logic [BW-1:0] bus_bidx_o,
  output logic [1:0]    word_we_o,
  output logic [1:0]    byte_we_o,
  output logic [LW-1:0] cpu_len_o,
  output logic          cpu_valid_o,
  output logic [LW-1:0] tx_len_o,
  output logic          irq_o
);
  localparam logic [PW-1:0] WORDS_P = PW'(WORDS);
  localparam logic [LW-1:0] MAXL    = LW'(MAX_BYTES);

  logic                 sel_q, sel_n;
  logic [PW-1:0]        cptr_q, cptr_n;
  logic [LW-1:0]        bptr_q, bptr_n;
  logic [1:0][LW-1:0]   len_q, len_n;
  logic [1:0]           vld_q, vld_n;
  logic                 irq_q, irq_n;
  logic                 cpu_b, bus_b, word_ok, rx_ok;

  assign bus_b   = sel_q;
  assign cpu_b   = ~sel_q;
  assign word_ok = cptr_q < WORDS_P;
  assign rx_ok   = !IS_IN && rx_wr_i && (len_q[bus_b] < MAXL);

  always_comb begin
    sel_n  = sel_q;
    cptr_n = cptr_q;
    bptr_n = bptr_q;
    len_n  = len_q;
    vld_n  = vld_q;
    if (IS_IN) begin
      if (cpu_wr_i && word_ok) cptr_n = cptr_q + PW'(1);
      if (cpu_len_wr_i)        len_n[cpu_b] = (cpu_len_i > MAXL) ? MAXL : cpu_len_i;
      if (cpu_validate_i) begin
        vld_n[cpu_b] = 1'b1;
        cptr_n       = '0;
      end
      if (tx_next_i && (bptr_q < MAXL)) bptr_n = bptr_q + LW'(1);
      if (tx_done_i) begin
        vld_n[bus_b] = 1'b0;
        bptr_n       = '0;
      end
    end else begin
      if (cpu_rd_i && word_ok) cptr_n = cptr_q + PW'(1);
      if (rx_ok)               len_n[bus_b] = len_q[bus_b] + LW'(1);
    end
    if (cpu_clear_i) begin
      vld_n[cpu_b] = 1'b0;
      len_n[cpu_b] = '0;
      cptr_n       = '0;
    end
    // frame boundary: the only place the roles change
    if (swap_i) begin
      sel_n  = ~sel_q;
      cptr_n = '0;
      bptr_n = '0;
      if (!IS_IN) len_n[cpu_b] = '0;
    end
    irq_n = swap_i | (irq_q & ~irq_ack_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      cptr_q <= '0;
      bptr_q <= '0;
      len_q  <= '0;
      vld_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      sel_q  <= sel_n;
      cptr_q <= cptr_n;
      bptr_q <= bptr_n;
      len_q  <= len_n;
      vld_q  <= vld_n;
      irq_q  <= irq_n;
    end
  end

  always_comb begin
    word_we_o = '0;
    byte_we_o = '0;
    word_we_o[cpu_b] = IS_IN && cpu_wr_i && word_ok;
    byte_we_o[bus_b] = rx_ok;
  end

  assign bus_sel_o   = sel_q;
  assign cpu_widx_o  = cptr_q[WW-1:0];
  assign bus_bidx_o  = IS_IN ? bptr_q[BW-1:0] : len_q[bus_b][BW-1:0];
  assign cpu_len_o   = len_q[cpu_b];
  assign cpu_valid_o = vld_q[cpu_b];
  assign tx_len_o    = (IS_IN && vld_q[bus_b]) ? len_q[bus_b] : '0;
  assign irq_o       = irq_q;
endmodule

// File: rtl/iso_dbuf_ep.sv
module iso_dbuf_ep
  import iso_dbuf_pkg::*;
#(
  parameter bit          IS_IN        = 1'b1,
  parameter int unsigned MAX_BYTES    = 64,
  parameter int unsigned FRAME_CYCLES = 12000
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             sof_i,
  output logic                             frame_o,
  output logic                             irq_o,
  input  logic                             irq_ack_i,
  input  logic                             cpu_wr_i,
  input  logic [31:0]                      cpu_wdata_i,
  input  logic                             cpu_rd_i,
  output logic [31:0]                      cpu_rdata_o,
  input  logic                             cpu_len_wr_i,
  input  logic [$clog2(MAX_BYTES+1)-1:0]   cpu_len_i,
  output logic [$clog2(MAX_BYTES+1)-1:0]   cpu_len_o,
  input  logic                             cpu_validate_i,
  input  logic                             cpu_clear_i,
  output logic                             cpu_valid_o,
  output logic [$clog2(MAX_BYTES+1)-1:0]   tx_len_o,
  output logic [7:0]                       tx_byte_o,
  input  logic                             tx_next_i,
  input  logic                             tx_done_i,
  input  logic [7:0]                       rx_byte_i,
  input  logic                             rx_wr_i
);
  localparam int unsigned BW = $clog2(MAX_BYTES);
  localparam int unsigned WW = $clog2(MAX_BYTES / 4);

  logic          rst_sn;
  logic          bus_sel;
  logic [WW-1:0] cpu_widx;
  logic [BW-1:0] bus_bidx;
  logic [1:0]    word_we, byte_we;
  word_t         rword [2];
  byte_t         rbyte [2];

  iso_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sn)
  );

  iso_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_sn),
    .sof_i   (sof_i),
    .frame_o (frame_o)
  );

  iso_dbuf_ctrl #(.IS_IN(IS_IN), .MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_sn),
    .swap_i         (frame_o),
    .irq_ack_i      (irq_ack_i),
    .cpu_wr_i       (cpu_wr_i),
    .cpu_rd_i       (cpu_rd_i),
    .cpu_len_wr_i   (cpu_len_wr_i),
    .cpu_len_i      (cpu_len_i),
    .cpu_validate_i (cpu_validate_i),
    .cpu_clear_i    (cpu_clear_i),
    .tx_next_i      (tx_next_i),
    .tx_done_i      (tx_done_i),
    .rx_wr_i        (rx_wr_i),
    .bus_sel_o      (bus_sel),
    .cpu_widx_o     (cpu_widx),
    .bus_bidx_o     (bus_bidx),
    .word_we_o      (word_we),
    .byte_we_o      (byte_we),
    .cpu_len_o      (cpu_len_o),
    .cpu_valid_o    (cpu_valid_o),
    .tx_len_o       (tx_len_o),
    .irq_o          (irq_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    iso_bank #(.MAX_BYTES(MAX_BYTES)) u_bank (
      .clk_i      (clk_i),
      .word_we_i  (word_we[g]),
      .word_idx_i (cpu_widx),
      .word_i     (cpu_wdata_i),
      .word_o     (rword[g]),
      .byte_we_i  (byte_we[g]),
      .byte_idx_i (bus_bidx),
      .byte_i     (rx_byte_i),
      .byte_o     (rbyte[g])
    );
  end

  assign cpu_rdata_o = rword[~bus_sel];
  assign tx_byte_o   = rbyte[bus_sel];
endmodule

// File: rtl/iso_dbuf_chk.sv
module iso_dbuf_chk #(
  parameter int unsigned FRAME_CYCLES = 12000,
  parameter int unsigned MAX_BYTES    = 64,
  localparam int unsigned LW = $clog2(MAX_BYTES + 1)
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          frame_o,
  input logic          irq_o,
  input logic          irq_ack_i,
  input logic          bus_sel,
  input logic          tx_done_i,
  input logic [LW-1:0] tx_len_o,
  input logic          cpu_clear_i,
  input logic [LW-1:0] cpu_len_o,
  input logic          cpu_valid_o
);
  localparam logic [31:0]   GAP_MAX = 32'(FRAME_CYCLES);
  localparam logic [LW-1:0] MAXL    = LW'(MAX_BYTES);

  logic [31:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)               gap_q <= '0;
    else if (frame_o)         gap_q <= '0;
    else if (gap_q != '1)     gap_q <= gap_q + 32'd1;
  end

  // R1
  frame_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    gap_q <= GAP_MAX);

  // R3
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    frame_o |=> irq_o);

  // R3
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(irq_o) |-> $past(irq_ack_i));

  // R4
  swap_on_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    frame_o |=> !$stable(bus_sel));

  // R4
  no_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !frame_o |=> $stable(bus_sel));

  // R9
  done_zlp_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tx_done_i && !frame_o) |=> (tx_len_o == '0));

  // R11
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cpu_clear_i && !frame_o) |=> (cpu_len_o == '0 && !cpu_valid_o));

  // R11
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    cpu_len_o <= MAXL);
endmodule

bind iso_dbuf_ep iso_dbuf_chk #(
  .FRAME_CYCLES (FRAME_CYCLES),
  .MAX_BYTES    (MAX_BYTES)
) u_iso_dbuf_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sn),
  .frame_o     (frame_o),
  .irq_o       (irq_o),
  .irq_ack_i   (irq_ack_i),
  .bus_sel     (bus_sel),
  .tx_done_i   (tx_done_i),
  .tx_len_o    (tx_len_o),
  .cpu_clear_i (cpu_clear_i),
  .cpu_len_o   (cpu_len_o),
  .cpu_valid_o (cpu_valid_o)
);

// File: tb/test_iso_dbuf_ep.sv
module test_iso_dbuf_ep;
  localparam int unsigned MB = 16;
  localparam int unsigned FC = 100;
  localparam int unsigned LW = $clog2(MB + 1);

  logic clk, rst_n, sof, irq_ack;
  int   total = 0;
  int   bad   = 0;

  // IN endpoint signals
  logic          ip_frame, ip_irq, ip_wr, ip_rd, ip_len_wr, ip_val, ip_clr, ip_cvalid;
  logic          ip_next, ip_done, ip_rxwr;
  logic [31:0]   ip_wdata, ip_rdata;
  logic [LW-1:0] ip_len, ip_clen, ip_txlen;
  logic [7:0]    ip_txb, ip_rxb;
  // OUT endpoint signals
  logic          op_frame, op_irq, op_wr, op_rd, op_len_wr, op_val, op_clr, op_cvalid;
  logic          op_next, op_done, op_rxwr;
  logic [31:0]   op_wdata, op_rdata;
  logic [LW-1:0] op_len, op_clen, op_txlen;
  logic [7:0]    op_txb, op_rxb;

  iso_dbuf_ep #(.IS_IN(1'b1), .MAX_BYTES(MB), .FRAME_CYCLES(FC)) i_iso_dbuf_ep (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .frame_o(ip_frame), .irq_o(ip_irq),
    .irq_ack_i(irq_ack), .cpu_wr_i(ip_wr), .cpu_wdata_i(ip_wdata), .cpu_rd_i(ip_rd),
    .cpu_rdata_o(ip_rdata), .cpu_len_wr_i(ip_len_wr), .cpu_len_i(ip_len),
    .cpu_len_o(ip_clen), .cpu_validate_i(ip_val), .cpu_clear_i(ip_clr),
    .cpu_valid_o(ip_cvalid), .tx_len_o(ip_txlen), .tx_byte_o(ip_txb),
    .tx_next_i(ip_next), .tx_done_i(ip_done), .rx_byte_i(ip_rxb), .rx_wr_i(ip_rxwr));

  iso_dbuf_ep #(.IS_IN(1'b0), .MAX_BYTES(MB), .FRAME_CYCLES(FC)) i_iso_dbuf_ep_out (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .frame_o(op_frame), .irq_o(op_irq),
    .irq_ack_i(irq_ack), .cpu_wr_i(op_wr), .cpu_wdata_i(op_wdata), .cpu_rd_i(op_rd),
    .cpu_rdata_o(op_rdata), .cpu_len_wr_i(op_len_wr), .cpu_len_i(op_len),
    .cpu_len_o(op_clen), .cpu_validate_i(op_val), .cpu_clear_i(op_clr),
    .cpu_valid_o(op_cvalid), .tx_len_o(op_txlen), .tx_byte_o(op_txb),
    .tx_next_i(op_next), .tx_done_i(op_done), .rx_byte_i(op_rxb), .rx_wr_i(op_rxwr));

  initial clk = 1'b0;
  always #4ns clk = ~clk;   // 125 MHz

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_swap();
    sof = 1'b1; step(); sof = 1'b0; step();
  endtask

  task automatic t_reset();
    chk("R12", 32'(ip_frame), 0, "frame in reset");
    chk("R12", 32'(ip_irq), 0, "irq in reset");
    chk("R12", 32'(ip_clen), 0, "cpu len in reset");
    chk("R12", 32'(ip_txlen), 0, "tx len in reset");
    chk("R12", 32'(ip_cvalid), 0, "valid in reset");
  endtask

  task automatic t_timer();
    int n;
    sof = 1'b1; step(); sof = 1'b0;
    chk("R2", 32'(ip_frame), 1, "pulse after SoF");
    n = 0;
    do begin step(); n++; end while (!ip_frame && n < 400);
    chk("R2", n, FC, "cycles from SoF to next pulse");
    n = 0;
    do begin step(); n++; end while (!ip_frame && n < 400);
    chk("R1", n, FC, "free-running period");
  endtask

  task automatic t_irq();
    sof = 1'b1; step(); sof = 1'b0;
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    chk("R3", 32'(ip_irq), 1, "set wins over ack");
    step(); step(); step();
    chk("R3", 32'(ip_irq), 1, "irq held");
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    chk("R3", 32'(ip_irq), 0, "irq cleared by ack");
    step();
    chk("R3", 32'(ip_irq), 0, "irq stays clear");
  endtask

  task automatic t_in_basic();
    logic [31:0] w [4];
    w[0] = 32'hA3A2A1A0; w[1] = 32'hB3B2B1B0; w[2] = 32'hC3C2C1C0; w[3] = 32'hD3D2D1D0;
    do_swap();
    for (int i = 0; i < 4; i++) begin
      ip_wr = 1'b1; ip_wdata = w[i]; step();
    end
    ip_wr = 1'b0;
    ip_len_wr = 1'b1; ip_len = LW'(13); step(); ip_len_wr = 1'b0;
    ip_val = 1'b1; step(); ip_val = 1'b0;
    chk("R5", 32'(ip_cvalid), 1, "software buffer marked ready");
    chk("R4", 32'(ip_clen), 13, "no swap on ready");
    chk("R5", 32'(ip_txlen), 0, "unready bus buffer gives zero length");
    do_swap();
    chk("R5", 32'(ip_txlen), 13, "ready buffer length on bus side");
    for (int k = 0; k < 13; k++) begin
      chk("R6", 32'(ip_txb), 32'(w[k/4][8*(k%4) +: 8]), $sformatf("byte %0d", k));
      ip_next = 1'b1; step(); ip_next = 1'b0;
    end
    ip_done = 1'b1; step(); ip_done = 1'b0;
    chk("R9", 32'(ip_txlen), 0, "done clears ready");
    chk("R10", 32'(ip_clen), 0, "other buffer length");
    do_swap();
    chk("R10", 32'(ip_clen), 13, "length follows buffer back");
    chk("R9", 32'(ip_cvalid), 0, "returned buffer not ready");
  endtask

  task automatic t_in_zlp();
    do_swap();
    ip_len_wr = 1'b1; ip_len = LW'(7); step(); ip_len_wr = 1'b0;
    do_swap();
    chk("R5", 32'(ip_txlen), 0, "unvalidated buffer sends zero length");
    ip_len_wr = 1'b1; ip_len = LW'(20); step(); ip_len_wr = 1'b0;
    chk("R11", 32'(ip_clen), MB, "length clamped");
    ip_val = 1'b1; step(); ip_val = 1'b0;
    chk("R4", 32'(ip_clen), MB, "ready keeps buffer");
    chk("R4", 32'(ip_cvalid), 1, "ready keeps buffer flag");
    ip_clr = 1'b1; step(); ip_clr = 1'b0;
    chk("R11", 32'(ip_clen), 0, "clear empties length");
    chk("R11", 32'(ip_cvalid), 0, "clear drops ready");
    chk("R4", 32'(ip_txlen), 0, "clear does not swap");
  endtask

  task automatic t_out();
    do_swap();
    for (int i = 0; i < 6; i++) begin
      op_rxwr = 1'b1; op_rxb = 8'(8'h11 + i); step();
    end
    op_rxwr = 1'b0;
    chk("R8", 32'(op_clen), 0, "receive goes to bus side");
    do_swap();
    chk("R8", 32'(op_clen), 6, "received count after swap");
    chk("R7", op_rdata, 32'h14131211, "word 0 little endian");
    op_rd = 1'b1; step(); op_rd = 1'b0;
    chk("R7", {16'h0, op_rdata[15:0]}, 32'h1615, "word 1 low half");
    for (int i = 0; i < 20; i++) begin
      op_rxwr = 1'b1; op_rxb = 8'(8'h40 + i); step();
    end
    op_rxwr = 1'b0;
    do_swap();
    chk("R8", 32'(op_clen), MB, "count stops at limit");
    for (int n = 0; n < 4; n++) begin
      chk("R7", op_rdata, {8'(8'h43 + 4*n), 8'(8'h42 + 4*n), 8'(8'h41 + 4*n), 8'(8'h40 + 4*n)},
          $sformatf("full word %0d", n));
      op_rd = 1'b1; step(); op_rd = 1'b0;
    end
    do_swap();
    op_rxwr = 1'b1; op_rxb = 8'hE0; step();
    op_rxb = 8'hE1; step(); op_rxwr = 1'b0;
    do_swap();
    chk("R8", 32'(op_clen), 2, "occupied buffer rewritten");
    chk("R8", {16'h0, op_rdata[15:0]}, 32'hE1E0, "rewritten data");
    op_clr = 1'b1; step(); op_clr = 1'b0;
    chk("R11", 32'(op_clen), 0, "clear on OUT");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sof = 1'b0; irq_ack = 1'b0;
    ip_wr = 0; ip_rd = 0; ip_len_wr = 0; ip_val = 0; ip_clr = 0; ip_next = 0; ip_done = 0;
    ip_rxwr = 0; ip_wdata = '0; ip_len = '0; ip_rxb = '0;
    op_wr = 0; op_rd = 0; op_len_wr = 0; op_val = 0; op_clr = 0; op_next = 0; op_done = 0;
    op_rxwr = 0; op_wdata = '0; op_len = '0; op_rxb = '0;
    repeat (4) step();
    t_reset();
    rst_n = 1'b1;
    repeat (3) step();
    t_timer();
    t_irq();
    t_in_basic();
    t_in_zlp();
    t_out();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule